// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Engine

This block is the bus-facing front end of an interrupt redirection engine. Software reaches every register through two locations. It first writes a register index into a select location. It then reads or writes the chosen register through a data window. Behind the window sit an identification register, a version register, an arbitration register and a table of 64-bit redirection entries. Each entry is split into two 32-bit halves, so every entry takes two consecutive indices.

The block holds the table itself. Each time a half is written, it hands the whole updated entry to the delivery engine on a write port and pulses a trigger that starts a service scan. The delivery engine owns each entry's remote-pending status bit and returns its live value on `remote_irr`. The block shows that value in reads and never lets software change it.

The request port follows valid/ready. `req_ready` is always high, so there is no back-pressure and every request with `req_valid` high is accepted at that clock edge. Exactly one cycle later, `rsp_valid` is high for one cycle and `rsp_rdata` holds the read data. A write returns zero, and the response cannot be stalled. Decoding uses only address bits [7:0]. The select location is at offset 0x00 and the window is at offset 0x10.

Top module: `irqw_top`

## Requirements
- R1: A write to offset 0x00 stores `req_wdata[7:0]` as the select index, whatever the access size. A read of offset 0x00 returns that index in bits [7:0], with zeros above.
- R2: A window access whose `req_size` is not 4 bytes is discarded: a write changes nothing and a read returns zero.
- R3: Index 0x00 is the ID register. A write keeps only `req_wdata[27:24]`, and a read returns that 4-bit ID in bits [27:24] with all other bits zero.
- R4: Index 0x01 is read-only. It reads as version code 0x11 in bits [7:0] and the entry count minus one in bits [23:16] (0x00170011 for 24 entries).
- R5: Index 0x02 is the arbitration register. It always reads zero and ignores writes.
- R6: Index 0x10+2k selects bits [31:0] of entry k and index 0x11+2k selects bits [63:32]. A write changes only the selected half.
- R7: On the cycle after a 4-byte window write to a table index is accepted, `tbl_wr_en` and `scan_start` pulse for exactly one cycle. At that time `tbl_wr_idx` holds the entry number and `tbl_wr_data` holds the full updated entry.
- R8: These all read zero and ignore writes: indices 0x03–0x0F, indices past the last entry, and any offset other than 0x00 and 0x10.
- R9: Entry bit 14 reads as the live `remote_irr` bit of that entry, and a window write to it has no effect.
- R10: After reset, the select index, the ID and all upper halves are zero. Every lower half reads 0x00010000 (bit 16, the mask bit, set). No response or table-write pulse is active.
- R11: Address bits above [7:0] are ignored, so offsets 0x100 and 0x110 behave like 0x00 and 0x10.
- R12: `req_ready` stays high. Each accepted request produces exactly one `rsp_valid` pulse one cycle later, and no cycle without a request produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte address; only bits [7:0] are decoded |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes |
| remote_irr | input | NPINS (24) | Live remote-pending bit of each entry from the engine |
| tbl_wr_en | output | 1 | Table entry update pulse |
| tbl_wr_idx | output | IDXW (5) | Updated entry number |
| tbl_wr_data | output | 64 | Full updated entry |
| scan_start | output | 1 | Starts a service scan in the engine |

## Verification
The window is driven with a walked table of select/window sequences that covers each index class: ID, version, arbitration, low and high table halves, gap indices, indices beyond the table, and unmapped offsets. Each class reads back a different value, so a wrong decode shows up as a wrong data word. Writing one half of an entry and then reading the other half separates a correct half-write from one that clobbers the neighbouring half. Writing all-ones to the ID separates correct field masking from a plain store. Narrow window accesses, accesses through aliased upper addresses, and reads taken while `remote_irr` is toggled separate the size filter, the address truncation and the live status bit from stored state.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam logic [7:0] OFS_SEL    = 8'h00;
  localparam logic [7:0] OFS_WIN    = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TBL    = 8'h10;
  localparam logic [7:0] VER_CODE   = 8'h11;
  localparam int         ID_LSB     = 24;
  localparam int         ID_W       = 4;
  localparam int         REMOTE_BIT = 14;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } tgt_e;
endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
  import irqw_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic [7:0]      sel,
  output tgt_e            tgt,
  output logic [IDXW-1:0] ent,
  output logic            hi
);
  logic [7:0] rel;

  always_comb begin
    rel = sel - IDX_TBL;
    tgt = TGT_NONE;
    ent = '0;
    hi  = sel[0];
    unique case (sel)
      IDX_ID:  tgt = TGT_ID;
      IDX_VER: tgt = TGT_VER;
      IDX_ARB: tgt = TGT_ARB;
      default: begin
        if (sel >= IDX_TBL && 32'(rel[7:1]) < NPINS) begin
          tgt = TGT_TBL;
          ent = IDXW'(rel[7:1]);
        end
      end
    endcase
  end
endmodule

// File: rtl/irqw_ident.sv
module irqw_ident
  import irqw_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] id_rd,
  output logic [31:0] ver_rd
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (wr_en) id_q <= wdata[ID_LSB +: ID_W];
  end

  always_comb begin
    id_rd                 = '0;
    id_rd[ID_LSB +: ID_W] = id_q;
    ver_rd                = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};
  end
endmodule

// File: rtl/irqw_entry_store.sv
module irqw_entry_store
  import irqw_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic            hi,
  input  logic [31:0]     wdata,
  input  logic [NPINS-1:0] remote_irr,
  output logic [31:0]     rd_data,
  output logic            tbl_wr_en,
  output logic [IDXW-1:0] tbl_wr_idx,
  output logic [63:0]     tbl_wr_data,
  output logic            scan_start
);
  logic [63:0] ent_q [NPINS];
  logic [63:0] cur;
  logic [63:0] nxt;
  logic        live;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ent_q[g] <= ENTRY_RST;
      else if (wr_en && 32'(idx) == g)            ent_q[g] <= nxt;
    end
  end

  always_comb begin
    cur  = '0;
    live = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (32'(idx) == i) begin
        cur  = ent_q[i];
        live = remote_irr[i];
      end
    end
    nxt = cur;
    if (hi) nxt[63:32] = wdata;
    else    nxt[31:0]  = wdata;
    nxt[REMOTE_BIT] = 1'b0;
    cur[REMOTE_BIT] = live;
    rd_data = hi ? cur[63:32] : cur[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_wr_en   <= 1'b0;
      scan_start  <= 1'b0;
      tbl_wr_idx  <= '0;
      tbl_wr_data <= '0;
    end else begin
      tbl_wr_en  <= wr_en;
      scan_start <= wr_en;
      if (wr_en) begin
        tbl_wr_idx              <= idx;
        tbl_wr_data             <= nxt;
        tbl_wr_data[REMOTE_BIT] <= live;
      end
    end
  end
endmodule

// File: rtl/irqw_top.sv
module irqw_top
  import irqw_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic [NPINS-1:0] remote_irr,
  output logic             tbl_wr_en,
  output logic [IDXW-1:0]  tbl_wr_idx,
  output logic [63:0]      tbl_wr_data,
  output logic             scan_start
);
  logic [7:0]      off;
  logic [7:0]      sel_q;
  logic            is_sel, win_ok, win_wr;
  tgt_e            tgt;
  logic [IDXW-1:0] ent;
  logic            hi;
  logic [31:0]     id_rd, ver_rd, tbl_rd, rd_mux;

  assign req_ready = 1'b1;
  assign off       = req_addr[7:0];
  assign is_sel    = off == OFS_SEL;
  assign win_ok    = (off == OFS_WIN) && (req_size == 3'd4);
  assign win_wr    = req_valid && req_write && win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sel_q <= '0;
    else if (req_valid && req_write && is_sel) sel_q <= req_wdata[7:0];
  end

  irqw_decode #(.NPINS(NPINS)) u_dec (
    .sel (sel_q),
    .tgt (tgt),
    .ent (ent),
    .hi  (hi)
  );

  irqw_ident #(.NPINS(NPINS)) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (win_wr && tgt == TGT_ID),
    .wdata  (req_wdata),
    .id_rd  (id_rd),
    .ver_rd (ver_rd)
  );

  irqw_entry_store #(.NPINS(NPINS)) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (win_wr && tgt == TGT_TBL),
    .idx         (ent),
    .hi          (hi),
    .wdata       (req_wdata),
    .remote_irr  (remote_irr),
    .rd_data     (tbl_rd),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_idx  (tbl_wr_idx),
    .tbl_wr_data (tbl_wr_data),
    .scan_start  (scan_start)
  );

  always_comb begin
    rd_mux = '0;
    if (is_sel) begin
      rd_mux = {24'h0, sel_q};
    end else if (win_ok) begin
      unique case (tgt)
        TGT_ID:  rd_mux = id_rd;
        TGT_VER: rd_mux = ver_rd;
        TGT_TBL: rd_mux = tbl_rd;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'h0;
    end
  end
endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [2:0]    req_size,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata,
  input logic          tbl_wr_en,
  input logic          scan_start,
  input logic [7:0]    sel_q
);
  p_always_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_extra_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_narrow_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[7:0] == 8'h10 && req_size != 3'd4)
    |=> rsp_rdata == 32'h0);

  p_arb_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[7:0] == 8'h10 && sel_q == 8'h02)
    |=> rsp_rdata == 32'h0);

  p_sel_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[7:0] == 8'h00)
    |=> rsp_rdata == {24'h0, $past(sel_q)});

  p_scan_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> tbl_wr_en);

  p_write_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> $past(req_valid && req_write && req_addr[7:0] == 8'h10 &&
                        req_size == 3'd4));
endmodule

bind irqw_top irqw_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .tbl_wr_en  (tbl_wr_en),
  .scan_start (scan_start),
  .sel_q      (sel_q)
);

// File: tb/test_irqw_top.sv
`timescale 1ns/1ps
module test_irqw_top;
  localparam int AW = 12;
  localparam int NPINS = 24;
  localparam int IDXW = $clog2(NPINS);

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 3'd4, 32'h0000_0000, 1'b0, 32'h0, 4'd3},   // R3 select ID
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0, 4'd3},   // R3 ID reset
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd3},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0F00_0000, 4'd3},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0001, 1'b0, 32'h0, 4'd4},   // R4 version
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0017_0011, 4'd4},
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd4},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0017_0011, 4'd4},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0002, 1'b0, 32'h0, 4'd5},   // R5 arbitration
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd5},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0, 4'd5},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0010, 1'b0, 32'h0, 4'd10},  // R10 entry0 low reset
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0001_0000, 4'd10},
    '{1'b1, 12'h010, 3'd4, 32'h0000_C031, 1'b0, 32'h0, 4'd9},   // R9 bit14 not stored
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0000_8031, 4'd9},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0011, 1'b0, 32'h0, 4'd6},   // R6 entry0 high
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0, 4'd6},
    '{1'b1, 12'h010, 3'd4, 32'hAB00_0000, 1'b0, 32'h0, 4'd6},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'hAB00_0000, 4'd6},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0010, 1'b0, 32'h0, 4'd6},   // R6 low half intact
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0000_8031, 4'd6},
    '{1'b1, 12'h000, 3'd4, 32'h0000_003F, 1'b0, 32'h0, 4'd6},   // R6 last entry high
    '{1'b1, 12'h010, 3'd4, 32'h1234_5678, 1'b0, 32'h0, 4'd6},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h1234_5678, 4'd6},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0040, 1'b0, 32'h0, 4'd8},   // R8 past table
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd8},
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0, 4'd8},
    '{1'b1, 12'h000, 3'd4, 32'h0000_0005, 1'b0, 32'h0, 4'd8},   // R8 gap index
    '{1'b0, 12'h010, 3'd4, 32'h0,         1'b1, 32'h0, 4'd8},
    '{1'b0, 12'h000, 3'd4, 32'h0,         1'b1, 32'h0000_0005, 4'd1}, // R1
    '{1'b1, 12'h000, 3'd1, 32'hFFFF_FF00, 1'b0, 32'h0, 4'd1},   // R1 byte write
    '{1'b0, 12'h000, 3'd1, 32'h0,         1'b1, 32'h0, 4'd1},
    '{1'b1, 12'h008, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd8},   // R8 unmapped offset
    '{1'b0, 12'h008, 3'd4, 32'h0,         1'b1, 32'h0, 4'd8},
    '{1'b1, 12'h100, 3'd4, 32'h0000_0001, 1'b0, 32'h0, 4'd11},  // R11 alias
    '{1'b0, 12'h110, 3'd4, 32'h0,         1'b1, 32'h0017_0011, 4'd11}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [2:0]       req_size = 3'd4;
  logic [31:0]      req_wdata = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;
  logic [NPINS-1:0] remote_irr = '0;
  logic             tbl_wr_en;
  logic [IDXW-1:0]  tbl_wr_idx;
  logic [63:0]      tbl_wr_data;
  logic             scan_start;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  irqw_top #(.AW(AW), .NPINS(NPINS)) i_irqw_top (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_size (req_size), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .remote_irr (remote_irr),
    .tbl_wr_en (tbl_wr_en), .tbl_wr_idx (tbl_wr_idx),
    .tbl_wr_data (tbl_wr_data), .scan_start (scan_start)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, accepted at the next rising edge, response sampled one falling edge later
  task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    check("R12 rsp_valid after request", 64'(rsp_valid), 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check("R10 tbl_wr_en in reset", 64'(tbl_wr_en), 64'd0);
    check("R10 scan_start in reset", 64'(scan_start), 64'd0);
    check("R12 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 no response when idle", 64'(rsp_valid), 64'd0);
    access(1'b0, 12'h000, 3'd4, 32'h0, rd);
    check("R10 select index after reset", 64'(rd), 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd);
      if (VECS[i].chk) begin
        n_run++;
        if (rd !== VECS[i].exp) begin
          n_fail++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[i].req, i, rd, VECS[i].exp);
        end
      end
      if (!VECS[i].wr || VECS[i].addr[7:0] != 8'h10)
        check("R7 no table write pulse", 64'(tbl_wr_en), 64'd0);
    end

    // R2 narrow window accesses on the ID
    access(1'b1, 12'h000, 3'd4, 32'h0, rd);
    access(1'b1, 12'h010, 3'd2, 32'h0, rd);
    check("R2 narrow write no table pulse", 64'(tbl_wr_en), 64'd0);
    access(1'b0, 12'h010, 3'd4, 32'h0, rd);
    check("R2 ID unchanged after narrow write", 64'(rd), 64'h0F00_0000);
    access(1'b0, 12'h010, 3'd2, 32'h0, rd);
    check("R2 narrow read zero", 64'(rd), 64'd0);

    // R7 write pulse carries entry 1 and full data
    access(1'b1, 12'h000, 3'd4, 32'h12, rd);
    access(1'b1, 12'h010, 3'd4, 32'h0000_0055, rd);
    check("R7 tbl_wr_en", 64'(tbl_wr_en), 64'd1);
    check("R7 scan_start", 64'(scan_start), 64'd1);
    check("R7 tbl_wr_idx", 64'(tbl_wr_idx), 64'd1);
    check("R7 tbl_wr_data", tbl_wr_data, 64'h0000_0000_0000_0055);
    @(negedge clk);
    check("R7 single pulse", 64'({tbl_wr_en, scan_start}), 64'd0);
    check("R12 no response after idle cycle", 64'(rsp_valid), 64'd0);

    // R9 live remote bit
    remote_irr[1] = 1'b1;
    access(1'b0, 12'h010, 3'd4, 32'h0, rd);
    check("R9 live remote bit read", 64'(rd), 64'h0000_4055);
    access(1'b1, 12'h010, 3'd4, 32'h0000_0066, rd);
    check("R9 write pulse shows live bit", tbl_wr_data, 64'h0000_0000_0000_4066);
    remote_irr[1] = 1'b0;
    access(1'b1, 12'h010, 3'd4, 32'h0000_4066, rd);
    access(1'b0, 12'h010, 3'd4, 32'h0, rd);
    check("R9 remote bit not writable", 64'(rd), 64'h0000_0066);

    // R10 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 12'h010, 3'd4, 32'h0, rd);
    check("R10 ID cleared by reset", 64'(rd), 64'd0);
    access(1'b1, 12'h000, 3'd4, 32'h12, rd);
    access(1'b0, 12'h010, 3'd4, 32'h0, rd);
    check("R10 entry low reset value", 64'(rd), 64'h0001_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule